// File: doc/BRIEF.md
# Top-of-Stack Buffer with Demand Spill and Fill

This block keeps the top entries of a core's data stack in a small on-chip ring of `DEPTH` words and uses a region of external memory for everything deeper. The core issues push and pop requests. A push that meets a full ring first writes the deepest ring entry out to memory. A pop that meets an empty ring first reads one word back from memory. In both cases the block raises `stall` for the memory cycles, and the core holds its request until `stall` drops.

Memory holds the spilled words at addresses `0` up to `spill_ptr-1`. The oldest word sits at address 0, so `spill_ptr` is also the number of words held in memory. For task switches, a save command writes only the occupied ring entries into memory, oldest first, and leaves `spill_ptr` pointing past them. The task manager keeps this pointer. A restore command loads a pointer and empties the ring. No words are read back during the restore: they return one at a time as later pops find the ring empty.

The memory port is single-ported. A write takes effect at the clock edge of the cycle that issues it. Read data is presented on `mem_rdata` in the cycle after the read is issued. The core raises at most one of `push_req` and `pop_req` in a cycle. If both are raised, the push is served and the pop is ignored.

Top module: `tos_spill_buffer`

## Requirements
- R1: A push to a ring that is not full completes in the cycle it is presented, with `stall` low and no memory access.
- R2: A pop from a ring that is not empty completes in the cycle it is presented, with `stall` low. `pop_data` carries the most recently pushed entry that has not yet been popped.
- R3: A push to a full ring raises `stall` for exactly one cycle. In that cycle it writes the deepest ring entry to memory address `spill_ptr`, and `spill_ptr` then increases by one. The push completes in the following cycle.
- R4: A pop from an empty ring while `spill_ptr` is nonzero raises `stall` for exactly two cycles and reads address `spill_ptr-1`. `spill_ptr` then decreases by one. The pop completes in the third cycle and returns the word read.
- R5: `stall` is high in every cycle in which `mem_en` is high, and a held request is not served until `stall` is low.
- R6: A pop while both the ring and the memory region are empty raises no stall and returns zero on `pop_data`. It sets `underflow_err`, which then stays set until reset.
- R7: A save is accepted only in a cycle with no push or pop request. From the next cycle on, it writes the occupied ring entries, and only those, oldest first to consecutive addresses starting at `spill_ptr`, one per cycle with `stall` high. `ctx_done` pulses `k+1` cycles after acceptance, where `k` is the number of occupied entries, and `spill_ptr` then points past the last word written.
- R8: A restore is accepted only in a cycle with no push or pop request. It pulses `ctx_done` in the same cycle. From the next cycle, `spill_ptr` equals `restore_ptr` and the ring is empty, so the next pop fills from memory as in R4.
- R9: `ctx_save` and `ctx_restore` raised together with a push or pop request are ignored: no done pulse, no stall and no change of `spill_ptr` follow.
- R10: After reset, `stall`, `underflow_err`, `ctx_done` and `mem_en` are low, `spill_ptr` is zero, and the ring is empty.
- R11: When save and restore are both requested in an accepted cycle, the save is performed and the restore is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Core requests a push |
| push_data | input | DW | Word to push |
| pop_req | input | 1 | Core requests a pop |
| pop_data | output | DW | Popped word, valid in the cycle a pop completes |
| stall | output | 1 | Core must hold its request |
| underflow_err | output | 1 | Sticky flag for a pop from a completely empty stack |
| ctx_save | input | 1 | Save command |
| ctx_restore | input | 1 | Restore command |
| restore_ptr | input | AW | Pointer loaded by a restore |
| ctx_done | output | 1 | One-cycle completion pulse for save or restore |
| spill_ptr | output | AW | Memory-side pointer: number of words held in memory |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after the read |

## Verification
The bench builds the block with `DEPTH=4`, `DW=16` and `AW=6`. At that depth, four pushes fill the ring, so spills, two consecutive spills, and a save of a partly filled ring all occur within a short test. A run of twenty pushes followed by twenty pops drives the memory region well past the ring depth and back. A behavioural memory model of 64 words, pre-filled with a marker value, shows that a save leaves the words past the occupied entries untouched. A restore to a mid-region pointer followed by pops exercises the on-demand refill, and pops past the bottom of the stack trigger the sticky error.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_SAVE = 2'd2
  } tsb_state_e;

  // next slot upward in a ring of d slots
  function automatic int ring_next(input int idx, input int d);
    return (idx == d - 1) ? 0 : idx + 1;
  endfunction

  // previous slot in a ring of d slots
  function automatic int ring_prev(input int idx, input int d);
    return (idx == 0) ? d - 1 : idx - 1;
  endfunction

  // slot of the deepest entry, given the free slot above the top and the occupancy
  function automatic int ring_deepest(input int top, input int occ, input int d);
    return (top + d - occ) % d;
  endfunction

endpackage

// File: rtl/tsb_ring.sv
module tsb_ring
  import tsb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [DW-1:0]                 wdata,
  input  logic                          pop,
  input  logic                          drop,
  input  logic                          clear,
  output logic [DW-1:0]                 top_data,
  output logic [DW-1:0]                 deep_data,
  output logic [$clog2(DEPTH+1)-1:0]    occ,
  output logic                          full,
  output logic                          empty
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH + 1);

  logic [DW-1:0] slot_q [DEPTH];
  logic [IW-1:0] top_q;
  logic [OW-1:0] occ_q;
  logic [IW-1:0] prev_idx, next_idx, deep_idx;

  assign prev_idx = IW'(ring_prev(int'(top_q), DEPTH));
  assign next_idx = IW'(ring_next(int'(top_q), DEPTH));
  assign deep_idx = IW'(ring_deepest(int'(top_q), int'(occ_q), DEPTH));

  always_ff @(posedge clk) begin
    if (push) slot_q[top_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q <= '0;
      occ_q <= '0;
    end else if (clear) begin
      occ_q <= '0;
    end else begin
      if (push)     top_q <= next_idx;
      else if (pop) top_q <= prev_idx;
      case ({push, pop | drop})
        2'b10:   occ_q <= occ_q + OW'(1);
        2'b01:   occ_q <= occ_q - OW'(1);
        default: occ_q <= occ_q;
      endcase
    end
  end

  assign top_data  = slot_q[prev_idx];
  assign deep_data = slot_q[deep_idx];
  assign occ       = occ_q;
  assign full      = (occ_q == OW'(DEPTH));
  assign empty     = (occ_q == '0);

  // R5
  ring_cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push, pop, drop}));
  // R2
  ring_occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OW'(DEPTH));
  // R2
  ring_pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop | drop) |-> !empty);
  // R1
  ring_push_nonfull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

endmodule

// File: rtl/tsb_ctrl.sv
module tsb_ctrl
  import tsb_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          ctx_save,
  input  logic          ctx_restore,
  input  logic [AW-1:0] restore_ptr,
  input  logic          full,
  input  logic          empty,
  output logic          ring_push,
  output logic          ring_sel_fill,
  output logic          ring_pop,
  output logic          ring_drop,
  output logic          ring_clear,
  output logic          underflow_now,
  output logic          stall,
  output logic          underflow_err,
  output logic          ctx_done,
  output logic [AW-1:0] spill_ptr,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr
);
  tsb_state_e    st_q;
  logic [AW-1:0] ptr_q;
  logic          err_q;

  logic idle, quiet, pop_sel;
  logic spill_go, push_go, pop_hit, fill_go, save_go, rest_go, save_wr, save_end;

  assign idle     = (st_q == ST_IDLE);
  assign quiet    = idle & !push_req & !pop_req;
  assign pop_sel  = idle & pop_req & !push_req;
  assign spill_go = idle & push_req & full;
  assign push_go  = idle & push_req & !full;
  assign pop_hit  = pop_sel & !empty;
  assign fill_go  = pop_sel & empty & (ptr_q != '0);
  assign underflow_now = pop_sel & empty & (ptr_q == '0);
  assign save_go  = quiet & ctx_save;
  assign rest_go  = quiet & ctx_restore & !ctx_save;
  assign save_wr  = (st_q == ST_SAVE) & !empty;
  assign save_end = (st_q == ST_SAVE) & empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ptr_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (underflow_now) err_q <= 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (fill_go)      st_q <= ST_FILL;
          else if (save_go) st_q <= ST_SAVE;
          if (spill_go)     ptr_q <= ptr_q + AW'(1);
          else if (rest_go) ptr_q <= restore_ptr;
        end
        ST_FILL: begin
          st_q  <= ST_IDLE;
          ptr_q <= ptr_q - AW'(1);
        end
        ST_SAVE: begin
          if (save_end) st_q <= ST_IDLE;
          else          ptr_q <= ptr_q + AW'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ring_push     = push_go | (st_q == ST_FILL);
  assign ring_sel_fill = (st_q == ST_FILL);
  assign ring_pop      = pop_hit;
  assign ring_drop     = spill_go | save_wr;
  assign ring_clear    = rest_go;
  assign stall         = !idle | spill_go | fill_go;
  assign underflow_err = err_q;
  assign ctx_done      = save_end | rest_go;
  assign spill_ptr     = ptr_q;
  assign mem_en        = spill_go | fill_go | save_wr;
  assign mem_we        = spill_go | save_wr;
  assign mem_addr      = fill_go ? (ptr_q - AW'(1)) : ptr_q;

  // R5
  mem_needs_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> stall);
  // R3
  spill_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && push_req && full) |=> (ptr_q == $past(ptr_q) + AW'(1)) && !full);
  // R4
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL) |=> !empty && idle);
  // R6
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R8
  restore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rest_go |=> empty && (ptr_q == $past(restore_ptr)));
  // R9
  cmd_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && (push_req || pop_req)) |-> !ctx_done);

endmodule

// File: rtl/tos_spill_buffer.sv
module tos_spill_buffer
  import tsb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] pop_data,
  output logic          stall,
  output logic          underflow_err,
  input  logic          ctx_save,
  input  logic          ctx_restore,
  input  logic [AW-1:0] restore_ptr,
  output logic          ctx_done,
  output logic [AW-1:0] spill_ptr,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int OW = $clog2(DEPTH + 1);

  logic          ring_push, ring_sel_fill, ring_pop, ring_drop, ring_clear;
  logic          full, empty, underflow_now;
  logic [DW-1:0] ring_wdata, top_data, deep_data;
  logic [OW-1:0] occ;

  assign ring_wdata = ring_sel_fill ? mem_rdata : push_data;

  tsb_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ring_push),
    .wdata     (ring_wdata),
    .pop       (ring_pop),
    .drop      (ring_drop),
    .clear     (ring_clear),
    .top_data  (top_data),
    .deep_data (deep_data),
    .occ       (occ),
    .full      (full),
    .empty     (empty)
  );

  tsb_ctrl #(.AW(AW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .push_req      (push_req),
    .pop_req       (pop_req),
    .ctx_save      (ctx_save),
    .ctx_restore   (ctx_restore),
    .restore_ptr   (restore_ptr),
    .full          (full),
    .empty         (empty),
    .ring_push     (ring_push),
    .ring_sel_fill (ring_sel_fill),
    .ring_pop      (ring_pop),
    .ring_drop     (ring_drop),
    .ring_clear    (ring_clear),
    .underflow_now (underflow_now),
    .stall         (stall),
    .underflow_err (underflow_err),
    .ctx_done      (ctx_done),
    .spill_ptr     (spill_ptr),
    .mem_en        (mem_en),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr)
  );

  assign mem_wdata = deep_data;
  assign pop_data  = underflow_now ? '0 : top_data;

  // R6
  underflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_now |-> (pop_data == '0) && !stall);
  // R7
  save_only_occupied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && !push_req) |-> (occ != '0));

endmodule

// File: tb/tos_spill_buffer_bench.sv
module tos_spill_buffer_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DEPTH = 4;
  localparam int DW    = 16;
  localparam int AW    = 6;
  localparam int MWORDS = 64;
  localparam logic [DW-1:0] MARK = 16'hDEAD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_req = 1'b0, pop_req = 1'b0, ctx_save = 1'b0, ctx_restore = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic [AW-1:0] restore_ptr = '0;
  logic [DW-1:0] pop_data, mem_wdata, mem_rdata;
  logic stall, underflow_err, ctx_done, mem_en, mem_we;
  logic [AW-1:0] spill_ptr, mem_addr;

  logic [DW-1:0] bmem [MWORDS];

  int total = 0;
  int bad = 0;

  // reference model
  int q[$];
  int emem[MWORDS];
  int mptr = 0;
  bit eerr = 0;

  always #2.5 clk = ~clk;

  tos_spill_buffer #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_tos_spill_buffer (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
    .pop_req(pop_req), .pop_data(pop_data), .stall(stall),
    .underflow_err(underflow_err), .ctx_save(ctx_save), .ctx_restore(ctx_restore),
    .restore_ptr(restore_ptr), .ctx_done(ctx_done), .spill_ptr(spill_ptr),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MWORDS; i++) bmem[i] <= MARK;
      mem_rdata <= '0;
    end else if (mem_en) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      else        mem_rdata <= bmem[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic common_chk(input string req);
    chk(int'(spill_ptr) == mptr, {req, " spill_ptr"}, int'(spill_ptr), mptr);
    chk(underflow_err == eerr, {req, " underflow_err"}, int'(underflow_err), int'(eerr));
  endtask

  task automatic push_op(input int v);
    int n = 0;
    int exp_st;
    string req;
    exp_st = (q.size() == DEPTH) ? 1 : 0;
    req = exp_st ? "R3" : "R1";
    push_req = 1'b1;
    push_data = DW'(v);
    forever begin
      #1;
      if (!stall) break;
      n++;
      @(negedge clk);
      if (n > 8) break;
    end
    chk(n == exp_st, {req, " stall cycles on push"}, n, exp_st);
    @(negedge clk);
    push_req = 1'b0;
    if (exp_st) begin
      emem[mptr] = q.pop_front();
      chk(int'(bmem[mptr]) == emem[mptr], "R3 spilled word", int'(bmem[mptr]), emem[mptr]);
      mptr++;
    end
    q.push_back(v);
    common_chk(req);
  endtask

  task automatic pop_op();
    int n = 0;
    int exp_st, exp_v;
    string req;
    if (q.size() != 0) begin
      exp_st = 0; exp_v = q.pop_back(); req = "R2";
    end else if (mptr > 0) begin
      exp_st = 2; mptr--; exp_v = emem[mptr]; req = "R4";
    end else begin
      exp_st = 0; exp_v = 0; eerr = 1; req = "R6";
    end
    pop_req = 1'b1;
    forever begin
      #1;
      if (!stall) break;
      n++;
      @(negedge clk);
      if (n > 8) break;
    end
    chk(n == exp_st, {req, " stall cycles on pop"}, n, exp_st);
    chk(int'(pop_data) == exp_v, {req, " pop_data"}, int'(pop_data), exp_v);
    @(negedge clk);
    pop_req = 1'b0;
    common_chk(req);
  endtask

  task automatic save_op();
    int k, n;
    k = q.size();
    ctx_save = 1'b1;
    #1;
    chk(!ctx_done && !stall, "R7 accept cycle quiet", {ctx_done, stall}, 0);
    @(negedge clk);
    ctx_save = 1'b0;
    n = 1;
    forever begin
      #1;
      chk(stall == 1'b1, "R7 stall during save", int'(stall), 1);
      if (ctx_done || n > 2 * DEPTH) break;
      n++;
      @(negedge clk);
    end
    chk(n == k + 1, "R7 done latency", n, k + 1);
    @(negedge clk);
    while (q.size() != 0) begin
      emem[mptr] = q.pop_front();
      chk(int'(bmem[mptr]) == emem[mptr], "R7 saved word", int'(bmem[mptr]), emem[mptr]);
      mptr++;
    end
    chk(bmem[mptr] == MARK, "R7 no write past occupied", int'(bmem[mptr]), int'(MARK));
    common_chk("R7");
  endtask

  task automatic restore_op(input int p);
    ctx_restore = 1'b1;
    restore_ptr = AW'(p);
    #1;
    chk(ctx_done == 1'b1, "R8 done same cycle", int'(ctx_done), 1);
    @(negedge clk);
    ctx_restore = 1'b0;
    q.delete();
    mptr = p;
    common_chk("R8");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk(!stall && !ctx_done && !mem_en, "R10 idle outputs", {stall, ctx_done, mem_en}, 0);
    common_chk("R10");
    @(negedge clk);

    push_op(16'h10); push_op(16'h11); push_op(16'h12);
    pop_op();                                // R2 returns 0x12
    push_op(16'h13); push_op(16'h14);        // ring full
    push_op(16'h15); push_op(16'h16);        // R3 two spills
    pop_op(); pop_op();
    save_op();                               // R7 with two occupied entries
    for (int i = 0; i < 4; i++) pop_op();    // R4 refills
    pop_op(); pop_op();                      // R6 underflow, sticky
    restore_op(2);                           // R8
    pop_op(); pop_op();                      // R4 after restore: 0x11, 0x10

    // R9: save raised together with a push is ignored
    push_req = 1'b1; push_data = 16'h21; ctx_save = 1'b1;
    #1;
    chk(!ctx_done && !stall, "R9 save with push ignored", {ctx_done, stall}, 0);
    @(negedge clk);
    push_req = 1'b0; ctx_save = 1'b0;
    q.push_back(16'h21);
    #1;
    chk(!ctx_done && !stall, "R9 no save started", {ctx_done, stall}, 0);
    common_chk("R9");
    @(negedge clk);
    pop_op();

    // R11: save and restore together, empty ring
    ctx_save = 1'b1; ctx_restore = 1'b1; restore_ptr = AW'(9);
    #1;
    chk(ctx_done == 1'b0, "R11 restore dropped", int'(ctx_done), 0);
    @(negedge clk);
    ctx_save = 1'b0; ctx_restore = 1'b0;
    #1;
    chk(ctx_done == 1'b1, "R11 empty save done", int'(ctx_done), 1);
    @(negedge clk);
    common_chk("R11");

    // long run through memory and back
    for (int i = 0; i < 20; i++) push_op(16'h100 + i);
    for (int i = 0; i < 20; i++) pop_op();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule